// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a four-beat burst. A base address is captured on a load cycle. The two low bits then walk through four beats, and the upper bits stay as captured. Each step happens on a clock edge where the active-low advance input is asserted. When advance is deasserted the address holds, which stretches the current beat into a wait state. After the fourth step the low bits return to the base value.

Two orderings are available, selected by a static input. The exclusive-or ordering forms each beat as the base low bits XOR'd with a beat count. The linear ordering adds the beat count to the base low bits, modulo four. Internally, one small beat counter is cleared on load and counts advances. The output is decoded from that count and the captured base.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted and after it is released, `addr_o` is all zeros until the first load.
- R2: On a clock edge with `load_i` high, the whole of `load_addr_i` is captured, and `addr_o` equals it right after that edge.
- R3: A load takes priority over advance. A load edge restarts the beat count at zero, even in the middle of a burst and even when `adv_n_i` is low.
- R4: With `order_sel_i` = 1 (XOR ordering), the low two bits after k advance edges since the load are `base[1:0] ^ k[1:0]`. Starting from 01, the beats are 01, 00, 11, 10.
- R5: With `order_sel_i` = 0 (linear ordering), the low two bits after k advance edges are `(base[1:0] + k) mod 4`. Starting from 11, the beats are 11, 00, 01, 10.
- R6: On an edge with `load_i` low and `adv_n_i` high, `addr_o` does not change.
- R7: After four advance edges without a load, the low two bits equal the loaded base again. The sequence then repeats.
- R8: Bits above the low two keep the loaded value for the whole burst, whatever the advance pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Capture a new base address and restart the burst |
| load_addr_i | input | ADDR_W | Base address to capture |
| adv_n_i | input | 1 | Active-low advance: step to the next beat |
| order_sel_i | input | 1 | 1 = XOR ordering, 0 = linear ordering; held static |
| addr_o | output | ADDR_W | Current burst address |

## Verification
A beat counter that is off by one, or not cleared on load, shows up on `addr_o` at the very next edge after a load or an advance. This is because the output is decoded from registers with no further delay. A counter that fails to wrap, or wraps early, shows up at the fourth advance as a low-bit value different from the base. A stuck hold shows up as a change on an edge where advance was idle. The bench walks every start value in both orderings and compares each beat. It also inserts wait states, and it reloads mid-burst with advance asserted.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } burst_order_e;
endpackage

// File: rtl/bseq_beat_ctr.sv
// Beat counter: cleared on load, stepped on advance, wraps naturally.
module bseq_beat_ctr #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr_i | step_i;
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/bseq_base_reg.sv
// Base address register with explicit load enable.
module bseq_base_reg #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q, q_d;

  always_comb q_d = d_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_q <= '0;
    else if (en_i) q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/bseq_order_map.sv
// Maps base low bits and beat count to the beat address for the chosen ordering.
module bseq_order_map
  import burst_seq_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] base_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             order_i,
  output logic [CNT_W-1:0] low_o
);
  logic [CNT_W-1:0] xor_beat, lin_beat;

  always_comb begin
    xor_beat = base_i ^ cnt_i;
    lin_beat = base_i + cnt_i;
    low_o    = (order_i == ORD_XOR) ? xor_beat : lin_beat;
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 15,
  parameter int LOW_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              adv_n_i,
  input  logic              order_sel_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int HI_W = ADDR_W - LOW_W;

  logic [ADDR_W-1:0] base_q;
  logic [LOW_W-1:0]  beat_cnt;
  logic [LOW_W-1:0]  low_addr;
  logic              step;

  always_comb step = !load_i && !adv_n_i;

  bseq_base_reg #(.W(ADDR_W)) i_base (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (load_i),
    .d_i   (load_addr_i),
    .q_o   (base_q)
  );

  bseq_beat_ctr #(.CNT_W(LOW_W)) i_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (load_i),
    .step_i (step),
    .cnt_o  (beat_cnt)
  );

  bseq_order_map #(.CNT_W(LOW_W)) i_map (
    .base_i  (base_q[LOW_W-1:0]),
    .cnt_i   (beat_cnt),
    .order_i (order_sel_i),
    .low_o   (low_addr)
  );

  assign addr_o = {base_q[ADDR_W-1:LOW_W], low_addr};

  // HI_W kept for clarity of the address split
  initial begin
    if (HI_W < 1) $error("ADDR_W must exceed LOW_W");
  end
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 15,
  parameter int LOW_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_i,
  input logic [ADDR_W-1:0] load_addr_i,
  input logic              adv_n_i,
  input logic              order_sel_i,
  input logic [ADDR_W-1:0] addr_o
);
  // R2: a load edge presents the captured address next
  a_r2_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> addr_o == $past(load_addr_i));

  // R6: idle advance holds the address
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && adv_n_i) |=> $stable(addr_o));

  // R8: upper bits never move without a load
  a_r8_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(addr_o[ADDR_W-1:LOW_W]));

  // R5: linear order steps the low bits by one
  a_r5_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_n_i && !order_sel_i) |=>
      addr_o[LOW_W-1:0] == $past(addr_o[LOW_W-1:0]) + LOW_W'(1));

  // R4: XOR order always moves the low bits on an advance
  a_r4_xor_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_n_i && order_sel_i) |=> !$stable(addr_o[LOW_W-1:0]));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .load_i      (load_i),
  .load_addr_i (load_addr_i),
  .adv_n_i     (adv_n_i),
  .order_sel_i (order_sel_i),
  .addr_o      (addr_o)
);

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 15;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          load_i;
  logic [AW-1:0] load_addr_i;
  logic          adv_n_i;
  logic          order_sel_i;
  logic [AW-1:0] addr_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .LOW_W(2)) i_burst_addr_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .load_addr_i (load_addr_i),
    .adv_n_i     (adv_n_i),
    .order_sel_i (order_sel_i),
    .addr_o      (addr_o)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: addr_o=%h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] beat(input logic ord, input logic [1:0] b, input int k);
    logic [1:0] kk = 2'(k);
    return ord ? (b ^ kk) : (b + kk);
  endfunction

  task automatic do_reset(input logic ord);
    rst_n = 1'b0; load_i = 1'b0; adv_n_i = 1'b1;
    load_addr_i = '0; order_sel_i = ord;
    #1;
    chk("R1 in reset", addr_o, '0);
    tick(); tick();
    rst_n = 1'b1;
    tick();
    chk("R1 after reset", addr_o, '0);
  endtask

  // Full burst from a base: four advances plus one more to see repeat
  task automatic t_burst(input logic ord, input logic [AW-1:0] base);
    load_i = 1'b1; load_addr_i = base; adv_n_i = 1'b0;
    tick();
    chk("R2/R3 load", addr_o, base);
    load_i = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      tick();
      chk(ord ? "R4 xor beat" : "R5 linear beat", addr_o,
          {base[AW-1:2], beat(ord, base[1:0], k)});
      if (k == 4) chk("R7 wrap", addr_o, base);
      chk("R8 upper", {addr_o[AW-1:2], 2'b00}, {base[AW-1:2], 2'b00});
    end
    adv_n_i = 1'b1;
  endtask

  // Wait states between beats
  task automatic t_hold(input logic ord, input logic [AW-1:0] base);
    load_i = 1'b1; load_addr_i = base; adv_n_i = 1'b1;
    tick();
    load_i = 1'b0; adv_n_i = 1'b0;
    tick();
    adv_n_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R6 hold", addr_o, {base[AW-1:2], beat(ord, base[1:0], 1)});
    end
    adv_n_i = 1'b0;
    tick();
    chk("R6 resume", addr_o, {base[AW-1:2], beat(ord, base[1:0], 2)});
    adv_n_i = 1'b1;
  endtask

  // Reload mid-burst with advance still asserted
  task automatic t_reload(input logic ord, input logic [AW-1:0] a0, input logic [AW-1:0] a1);
    load_i = 1'b1; load_addr_i = a0; adv_n_i = 1'b0;
    tick();
    load_i = 1'b0;
    tick(); tick();
    load_i = 1'b1; load_addr_i = a1;
    tick();
    chk("R3 reload", addr_o, a1);
    load_i = 1'b0;
    tick();
    chk("R3 count restarted", addr_o, {a1[AW-1:2], beat(ord, a1[1:0], 1)});
    adv_n_i = 1'b1;
  endtask

  initial begin
    do_reset(1'b1);
    for (int b = 0; b < 4; b++) t_burst(1'b1, AW'(15'h2A50 | b));
    t_hold(1'b1, 15'h1235);
    t_reload(1'b1, 15'h0F02, 15'h7001);
    do_reset(1'b0);
    for (int b = 0; b < 4; b++) t_burst(1'b0, AW'(15'h5A5C | b));
    t_hold(1'b0, 15'h3333);
    t_reload(1'b0, 15'h0102, 15'h4443);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule